// File: doc/BRIEF.md
# Edge-Strobed Software Watchdog

This block watches over running software. A counter runs while the processor is out of reset. Each high-to-low change on the strobe input sends it back to zero. If the counter reaches the timeout without such a change, the block pulls its active-low status line low for a fixed number of clock cycles. After that pulse it re-arms on its own and starts timing again from zero.

The strobe arrives already synchronized to `clk`. The `run_en` input comes from the reset generator and is high once the processor's reset has been released. While `run_en` is low, the block stays idle: the count is held at zero and the status line stays high. Both the timeout and the pulse width are counted in clock cycles. At the default 250 MHz clock, the default values give a 1 s timeout and a 130 ms pulse.

Top module: `wdg_strobe_supervisor`

## Requirements
- R1: While `rst_n` is sampled low, the next clock edge drives `wd_status_n` high (inactive) and clears all timing state. High is inactive and low is active.
- R2: While `run_en` is sampled low, the timeout count is held at zero and `wd_status_n` is high after the next edge.
- R3: A kick is `strobe` sampled 1 at one edge and 0 at the next edge. A kick seen while armed returns the count to zero, so the next timeout needs a further `TIMEOUT_CYC` edges without a kick.
- R4: With `run_en` high, count the edges that follow its assertion or the last kick, with no kick among them. The `TIMEOUT_CYC`-th such edge drives `wd_status_n` low.
- R5: Once driven low by a timeout, `wd_status_n` stays low for exactly `PULSE_CYC` cycles, provided `run_en` remains high.
- R6: When the pulse ends, timing restarts from zero by itself. With no kicks, the next pulse begins `TIMEOUT_CYC` cycles after `wd_status_n` returns high.
- R7: A strobe held static low or static high never counts as a kick, and neither does a rising transition.
- R8: A kick sampled at the same edge that would complete the timeout wins. No pulse starts and the count returns to zero.
- R9: Strobe activity during a pulse is ignored. It neither lengthens nor shortens the pulse, and it does not shift the next timeout.
- R10: If `run_en` is sampled low during a pulse, the pulse ends at that edge and `wd_status_n` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | High once the processor reset is released |
| strobe | input | 1 | Synchronized software strobe; falling edges are kicks |
| wd_status_n | output | 1 | Active-low watchdog status pulse |

## Verification
The bench targets four corner cases:
- A kick on the very edge that would expire the count. A design that gives the expiry priority would emit a spurious pulse.
- A strobe held low for longer than the timeout. A level-sensitive design would never time out.
- Strobe toggling during a pulse. A design that lets kicks reach the pulse or the counter would change the pulse width or move the next timeout.
- Dropping `run_en` mid-pulse, and the automatic re-arm after a pulse. These catch a status line that sticks low, and a second timeout that arrives early or never.

// File: rtl/wdg_pkg.sv
// Package: shared types and width helpers for the strobe watchdog.
// Assumes counter limits of at least 1.
package wdg_pkg;

    // Phase of the watchdog: timing the strobe, or driving the status pulse.
    typedef enum logic {
        WD_ARMED  = 1'b0,
        WD_FIRING = 1'b1
    } wd_phase_e;

    // Bits needed to count 0 .. n-1, never fewer than one.
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdg_edge_detect.sv
// Edge detector: flags a high-to-low change of the synchronized strobe.
// Assumes strobe is already in the clk domain. The idle level after reset
// is high, matching a pulled-up line.
module wdg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    // Remember the strobe level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/wdg_timeout_counter.sv
// Timeout counter: counts armed cycles and flags expiry after TIMEOUT_CYC.
// Assumes TIMEOUT_CYC >= 2. A kick takes priority over an expiry in the
// same cycle. The count is held at zero while hold or !run_en.
module wdg_timeout_counter #(
    parameter int TIMEOUT_CYC = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic hold,
    input  logic kick,
    output logic expire
);
    localparam int            CW   = wdg_pkg::cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] count_q;

    assign expire = run_en && !hold && !kick && (count_q == LAST);

    // Advance the count, or return it to zero on kick, hold, idle or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  count_q <= '0;
        else if (!run_en || hold || kick || expire)  count_q <= '0;
        else                                         count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/wdg_pulse_timer.sv
// Pulse timer: holds the firing phase for exactly PULSE_CYC cycles after a start.
// Assumes PULSE_CYC >= 1. Dropping run_en aborts the pulse at once.
module wdg_pulse_timer #(
    parameter int PULSE_CYC = 32_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic start,
    output logic active
);
    localparam int            PW   = wdg_pkg::cnt_width(PULSE_CYC);
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

    wdg_pkg::wd_phase_e phase_q;
    logic [PW-1:0]      width_q;

    // Sequence the phase: enter on start, leave after PULSE_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            phase_q <= wdg_pkg::WD_ARMED;
            width_q <= '0;
        end else if (phase_q == wdg_pkg::WD_FIRING) begin
            if (width_q == LAST) begin
                phase_q <= wdg_pkg::WD_ARMED;
                width_q <= '0;
            end else begin
                width_q <= width_q + 1'b1;
            end
        end else if (start) begin
            phase_q <= wdg_pkg::WD_FIRING;
            width_q <= '0;
        end
    end

    assign active = (phase_q == wdg_pkg::WD_FIRING);
endmodule

// File: rtl/wdg_strobe_supervisor.sv
// Top: software watchdog kicked by strobe falling edges.
// When no kick arrives within TIMEOUT_CYC cycles, it emits an active-low
// status pulse of PULSE_CYC cycles and then re-arms. It stays idle while
// run_en is low. Assumes strobe is synchronized to clk.
module wdg_strobe_supervisor #(
    parameter int TIMEOUT_CYC = 250_000_000,
    parameter int PULSE_CYC   = 32_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic strobe,
    output logic wd_status_n
);
    logic kick;
    logic expire;
    logic firing;

    wdg_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .fall   (kick)
    );

    wdg_timeout_counter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .hold   (firing),
        .kick   (kick),
        .expire (expire)
    );

    wdg_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .start  (expire),
        .active (firing)
    );

    // Status line is the inverted firing phase, straight from a register.
    assign wd_status_n = ~firing;
endmodule

// File: rtl/wdg_strobe_supervisor_checker.sv
// Checker: temporal properties of the watchdog, observed at its ports.
// It keeps its own run-length counters for the long windows.
module wdg_strobe_supervisor_checker #(
    parameter int TIMEOUT_CYC = 250_000_000,
    parameter int PULSE_CYC   = 32_500_000
) (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic strobe,
    input logic wd_status_n
);
    int low_len;
    int high_run;

    // Length of the current low stretch of the status line.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_len <= 0;
        else if (!wd_status_n) low_len <= low_len + 1;
        else                   low_len <= 0;
    end

    // Cycles the status line has stayed high with run_en asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)                    high_run <= 0;
        else if (run_en && wd_status_n) high_run <= high_run + 1;
        else                           high_run <= 0;
    end

    AST_RESET_LEAVES_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> wd_status_n); // R1
    AST_IDLE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> wd_status_n); // R2
    AST_KICK_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (run_en && wd_status_n && $past(strobe) && !strobe) |=> wd_status_n); // R3
    AST_TIMEOUT_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(wd_status_n) |-> (high_run >= TIMEOUT_CYC)); // R4
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) ($rose(wd_status_n) && run_en && $past(run_en)) |-> (low_len == PULSE_CYC)); // R5
    AST_LOW_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) !wd_status_n |-> $past(run_en)); // R10
endmodule

bind wdg_strobe_supervisor wdg_strobe_supervisor_checker #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .PULSE_CYC   (PULSE_CYC)
) u_wdg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .strobe      (strobe),
    .wd_status_n (wd_status_n)
);

// File: tb/test_wdg_strobe_supervisor.sv
// Scoreboard bench: the driver applies stimulus, predicts the status level
// from the requirements and queues it; the monitor compares at each negedge.
module test_wdg_strobe_supervisor;
    localparam int T = 20;
    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic strobe = 1'b1;
    logic wd_status_n;

    always #2 clk = ~clk;

    wdg_strobe_supervisor #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) i_wdg_strobe_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .strobe      (strobe),
        .wd_status_n (wd_status_n)
    );

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    item_t it;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Requirement-level prediction state.
    int m_elapsed = 0;
    int m_left = 0;
    bit m_pulse = 1'b0;
    bit m_hist = 1'b1;
    bit a_rst_n = 1'b0;
    bit a_run = 1'b0;
    bit a_strb = 1'b1;

    // One clock: predict the effect of the edge, queue it, drive new inputs.
    task automatic cyc(input bit r_n, input bit run, input bit s, input string req);
        bit fall;
        @(posedge clk);
        if (!a_rst_n) begin
            m_elapsed = 0; m_pulse = 1'b0; m_left = 0; m_hist = 1'b1;
        end else begin
            fall = m_hist && !a_strb;
            m_hist = a_strb;
            if (!a_run) begin
                m_elapsed = 0; m_pulse = 1'b0;
            end else if (m_pulse) begin
                m_left--;
                if (m_left == 0) begin m_pulse = 1'b0; m_elapsed = 0; end
            end else if (fall) begin
                m_elapsed = 0;
            end else begin
                m_elapsed++;
                if (m_elapsed == T) begin m_pulse = 1'b1; m_left = P; m_elapsed = 0; end
            end
        end
        q.push_back('{exp: !m_pulse, req: req});
        #1;
        rst_n = r_n; run_en = run; strobe = s;
        a_rst_n = r_n; a_run = run; a_strb = s;
    endtask

    // Monitor: compare each predicted level against the port.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (wd_status_n !== it.exp) begin
                errors++;
                $display("FAIL %s: wd_status_n actual=%b expected=%b at %0t",
                         it.req, wd_status_n, it.exp, $time);
            end
        end
    end

    initial begin
        repeat (4) cyc(1'b0, 1'b0, 1'b1, "R1");
        repeat (50) cyc(1'b1, 1'b0, 1'b1, "R2");
        // free-running timeouts: two pulses and a re-arm
        repeat (2 * (T + P) + 3) cyc(1'b1, 1'b1, 1'b1, "R4/R5/R6");
        repeat (3) cyc(1'b1, 1'b0, 1'b1, "R2");
        // regular kicks inside the window, then silence until timeout
        for (int k = 0; k < 5; k++) begin
            repeat (T - 4) cyc(1'b1, 1'b1, 1'b1, "R3");
            repeat (2) cyc(1'b1, 1'b1, 1'b0, "R3");
        end
        repeat (T + 4) cyc(1'b1, 1'b1, 1'b1, "R3");
        repeat (2) cyc(1'b1, 1'b0, 1'b1, "R2");
        // static low then static high (with one rising edge) must time out
        repeat (2 * T + P) cyc(1'b1, 1'b1, 1'b0, "R7");
        repeat (2 * T + P) cyc(1'b1, 1'b1, 1'b1, "R7");
        repeat (2) cyc(1'b1, 1'b0, 1'b1, "R2");
        // kick lands on the edge that would complete the timeout
        cyc(1'b1, 1'b1, 1'b1, "R8");
        repeat (T - 2) cyc(1'b1, 1'b1, 1'b1, "R8");
        repeat (T + P + 2) cyc(1'b1, 1'b1, 1'b0, "R8");
        repeat (2) cyc(1'b1, 1'b0, 1'b1, "R2");
        // strobe toggling during the pulse is ignored
        repeat (T + 1) cyc(1'b1, 1'b1, 1'b1, "R9");
        for (int k = 0; k < P / 2; k++) begin
            cyc(1'b1, 1'b1, 1'b0, "R9");
            cyc(1'b1, 1'b1, 1'b1, "R9");
        end
        repeat (T + 4) cyc(1'b1, 1'b1, 1'b1, "R9");
        repeat (2) cyc(1'b1, 1'b0, 1'b1, "R2");
        // run_en dropped in the middle of a pulse
        repeat (T + 2) cyc(1'b1, 1'b1, 1'b1, "R10");
        repeat (3) cyc(1'b1, 1'b0, 1'b1, "R10");
        repeat (T + 3) cyc(1'b1, 1'b1, 1'b1, "R10");
        // reset in the middle of a pulse
        repeat (2) cyc(1'b0, 1'b1, 1'b1, "R1");
        repeat (3) cyc(1'b1, 1'b1, 1'b1, "R1");
        repeat (2) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule